// File: doc/BRIEF.md
# Trigger Pulse Repeater with Rejection Window

The block turns an asynchronous trigger into a clean output pulse of fixed length. The trigger passes through a two-flop synchroniser and then an optional filter. The filter discards any high level that lasts only one clock cycle. A rising edge of the conditioned trigger then starts a pulse `PULSE_CYC` clock cycles long, as long as the block is enabled and idle.

After each pulse the block holds off new triggers for a rejection window. The window is sized so that two pulse starts are always at least `DUTY_DIV * PULSE_CYC` cycles apart. This caps the output duty cycle at one over `DUTY_DIV`. With the default 150-cycle width and a 125 MHz clock, the pulse is 1.2 us wide and the minimum repetition period is 6 us.

A trigger edge that arrives while a pulse is being generated or while the window is open is discarded. Each discarded edge raises a one-cycle error strobe, which the surrounding logic can count or latch.

Top module: `trig_repeater`

## Requirements
- R1: While `rst_n` is low, `pulse` and `drop_strb` are 0, whatever `trig_a` does.
- R2: With the filter off (`filt_en_n` = 1), an idle, enabled block raises `pulse` on the 4th rising clock edge after `trig_a` goes high.
- R3: Every pulse stays high for exactly `PULSE_CYC` consecutive cycles.
- R4: Two rising edges of `pulse` are never closer than `DUTY_DIV * PULSE_CYC` cycles. Trigger edges spaced exactly that far apart each produce a pulse. Edges spaced one cycle less drop the second one.
- R5: A trigger edge that reaches the sequencer while a pulse is high or the rejection window is open produces no pulse. It makes `drop_strb` high for exactly one cycle. Every dropped edge gives its own strobe.
- R6: With the filter on (`filt_en_n` = 0), a trigger high for a single clock cycle produces neither a pulse nor a strobe. A trigger high for two or more cycles raises `pulse` on the 5th rising edge.
- R7: With the filter off, a trigger high for a single clock cycle still produces a full pulse.
- R8: A trigger edge that arrives while `en` is low and the block is idle produces neither a pulse nor a strobe. A `pulse` rise only follows a cycle in which `en` was high.
- R9: A trigger held high for a long time produces a single pulse and no strobes, because only its rising edge counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| en | input | 1 | Allows new pulses to start when high |
| filt_en_n | input | 1 | Active-low enable of the one-cycle glitch filter |
| trig_a | input | 1 | Asynchronous trigger input |
| pulse | output | 1 | Output pulse, `PULSE_CYC` cycles wide |
| drop_strb | output | 1 | One-cycle strobe for each discarded trigger edge |

## Verification
The bench targets the edges of the hold-off window. Triggers spaced exactly at the minimum period must both be accepted, and triggers one cycle closer must lose the second. An off-by-one in the window counter would show up as a missing second pulse in the first case or an extra one in the second. The bench also sends a trigger that is high for a single cycle, with the filter on and with it off. A filter wired the wrong way would either let the glitch through or swallow it, and would also shift the measured start latency. Finally, it drops several edges inside one window and checks that each one gives its own single-cycle strobe. A strobe driven from the state alone would stretch or merge these strobes.

// File: rtl/trig_rep_pkg.sv
package trig_rep_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GEN  = 2'd1,
    ST_REJ  = 2'd2
  } rep_state_e;

  function automatic int unsigned bits_for(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);

  logic [STAGES-1:0] chain;
  logic [STAGES-1:0] chain_nxt;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_nxt = d_async;
    end else begin : g_multi
      always_comb chain_nxt = {chain[STAGES-2:0], d_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= chain_nxt;
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/trig_gfilt.sv
module trig_gfilt (
  input  logic clk,
  input  logic rst_n,
  input  logic filt_on,
  input  logic d,
  output logic q
);

  logic d_dly;
  logic q_nxt;

  // Filter on: the level must be seen on two successive cycles.
  always_comb begin
    if (filt_on) q_nxt = d & d_dly;
    else         q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_dly <= 1'b0;
      q     <= 1'b0;
    end else begin
      d_dly <= d;
      q     <= q_nxt;
    end
  end

endmodule

// File: rtl/trig_edge.sv
module trig_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise
);

  logic d_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_prev <= 1'b0;
    else        d_prev <= d;
  end

  assign rise = d & ~d_prev;

endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_rep_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 150,
  parameter int unsigned DUTY_DIV  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rise,
  output logic pulse,
  output logic drop_strb
);

  // One idle cycle is needed to accept an edge, so the window is trimmed by one.
  localparam int unsigned GEN_LAST = PULSE_CYC - 1;
  localparam int unsigned REJ_CYC  = (DUTY_DIV - 1) * PULSE_CYC - 1;
  localparam int unsigned REJ_LAST = REJ_CYC - 1;
  localparam int unsigned CNT_MAX  = (GEN_LAST > REJ_LAST) ? GEN_LAST : REJ_LAST;
  localparam int unsigned CW       = bits_for(CNT_MAX);
  localparam logic [CW-1:0] GEN_END = GEN_LAST[CW-1:0];
  localparam logic [CW-1:0] REJ_END = REJ_LAST[CW-1:0];

  rep_state_e    state, state_nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          drop_nxt;
  logic          cnt_en;

  always_comb begin
    state_nxt = state;
    cnt_nxt   = cnt;
    cnt_en    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (rise && en) begin
          state_nxt = ST_GEN;
          cnt_nxt   = '0;
          cnt_en    = 1'b1;
        end
      end
      ST_GEN: begin
        cnt_en = 1'b1;
        if (cnt == GEN_END) begin
          state_nxt = ST_REJ;
          cnt_nxt   = '0;
        end else begin
          cnt_nxt = cnt + 1'b1;
        end
      end
      ST_REJ: begin
        cnt_en = 1'b1;
        if (cnt == REJ_END) begin
          state_nxt = ST_IDLE;
          cnt_nxt   = '0;
        end else begin
          cnt_nxt = cnt + 1'b1;
        end
      end
      default: begin
        state_nxt = ST_IDLE;
        cnt_nxt   = '0;
        cnt_en    = 1'b1;
      end
    endcase
  end

  assign drop_nxt = rise && (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      drop_strb <= 1'b0;
    end else begin
      state     <= state_nxt;
      drop_strb <= drop_nxt;
      if (cnt_en) cnt <= cnt_nxt;
    end
  end

  assign pulse = (state == ST_GEN);

endmodule

// File: rtl/trig_repeater.sv
module trig_repeater #(
  parameter int unsigned PULSE_CYC   = 150,
  parameter int unsigned DUTY_DIV    = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic filt_en_n,
  input  logic trig_a,
  output logic pulse,
  output logic drop_strb
);

  logic rst_meta, rst_sync_n;
  logic trig_s, trig_f, trig_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .d_async (trig_a),
    .q       (trig_s)
  );

  trig_gfilt u_gfilt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .filt_on (~filt_en_n),
    .d       (trig_s),
    .q       (trig_f)
  );

  trig_edge u_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (trig_f),
    .rise  (trig_rise)
  );

  trig_seq #(.PULSE_CYC(PULSE_CYC), .DUTY_DIV(DUTY_DIV)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (en),
    .rise      (trig_rise),
    .pulse     (pulse),
    .drop_strb (drop_strb)
  );

endmodule

// File: rtl/trig_repeater_chk.sv
module trig_repeater_chk #(
  parameter int unsigned PULSE_CYC = 150,
  parameter int unsigned DUTY_DIV  = 5
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic pulse,
  input logic drop_strb
);

  localparam int unsigned MIN_SPACE = DUTY_DIV * PULSE_CYC;
  localparam int unsigned HW = $clog2(PULSE_CYC + 2);
  localparam int unsigned SW = $clog2(MIN_SPACE + 2);

  logic [HW-1:0] hi_cnt;
  logic [SW-1:0] since;
  logic          pulse_q, seen;
  logic          rise_now;

  assign rise_now = pulse & ~pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt  <= '0;
      since   <= '0;
      pulse_q <= 1'b0;
      seen    <= 1'b0;
    end else begin
      pulse_q <= pulse;
      seen    <= seen | rise_now;
      if (pulse) hi_cnt <= hi_cnt + 1'b1;
      else       hi_cnt <= '0;
      if (rise_now)                         since <= SW'(1);
      else if (since < SW'(MIN_SPACE))      since <= since + 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !pulse && !drop_strb); // R1

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse) |-> hi_cnt == HW'(PULSE_CYC)); // R3

  AST_PULSE_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> hi_cnt < HW'(PULSE_CYC)); // R3

  AST_MIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_now && seen) |-> since >= SW'(MIN_SPACE)); // R4

  AST_STRB_ONE_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    drop_strb |=> !drop_strb); // R5

  AST_STRB_NOT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> !drop_strb); // R5

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(en)); // R8

endmodule

bind trig_repeater trig_repeater_chk #(
  .PULSE_CYC (PULSE_CYC),
  .DUTY_DIV  (DUTY_DIV)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .pulse     (pulse),
  .drop_strb (drop_strb)
);

// File: tb/tb_trig_repeater.sv
`timescale 1ns/1ps
module tb_trig_repeater;

  localparam int W     = 8;
  localparam int DIV   = 3;
  localparam int SPACE = W * DIV;

  logic clk = 1'b0;
  logic rst_n, en, filt_en_n, trig_a;
  logic pulse, drop_strb;

  int checks = 0;
  int errs   = 0;

  int n_rise = 0, n_drop = 0, last_w = 0, run = 0, drun = 0, max_drun = 0;
  logic pulse_prev = 1'b0;

  always #5 clk = ~clk;

  trig_repeater #(.PULSE_CYC(W), .DUTY_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .filt_en_n(filt_en_n),
    .trig_a(trig_a), .pulse(pulse), .drop_strb(drop_strb)
  );

  always @(negedge clk) begin
    if (pulse && !pulse_prev) n_rise++;
    if (pulse) run++;
    else begin
      if (pulse_prev) last_w = run;
      run = 0;
    end
    pulse_prev = pulse;
    if (drop_strb) begin
      n_drop++;
      drun++;
      if (drun > max_drun) max_drun = drun;
    end else drun = 0;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Trigger high for two cycles, starting at the current negedge.
  task automatic fire();
    trig_a = 1'b1;
    @(negedge clk);
    @(negedge clk);
    trig_a = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b1; filt_en_n = 1'b1; trig_a = 1'b1;
    idle(3);
    chk("R1", "pulse in reset", pulse, 0);
    chk("R1", "strobe in reset", drop_strb, 0);
    trig_a = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(6);
    chk("R1", "pulse after reset", pulse, 0);
  endtask

  task automatic latency(input bit filt, input int exp_lat, input string req);
    int k = 0;
    filt_en_n = ~filt;
    trig_a = 1'b1;
    while (k < 20 && !pulse) begin
      @(negedge clk);
      k++;
      if (k == 3) trig_a = 1'b0;
    end
    trig_a = 1'b0;
    chk(req, "start latency", k, exp_lat);
    idle(SPACE + 8);
    chk("R3", "pulse width", last_w, W);
  endtask

  task automatic t_spacing(input int gap, input int exp_rise, input int exp_drop);
    int r0 = n_rise, d0 = n_drop;
    filt_en_n = 1'b1;
    fire();
    idle(gap - 2);
    fire();
    idle(SPACE + 8);
    chk("R4", $sformatf("pulses at gap %0d", gap), n_rise - r0, exp_rise);
    chk("R5", $sformatf("strobes at gap %0d", gap), n_drop - d0, exp_drop);
  endtask

  task automatic t_multi_drop();
    int r0 = n_rise, d0 = n_drop;
    max_drun = 0;
    fire();
    idle(4);
    fire();
    idle(6);
    fire();
    idle(SPACE + 8);
    chk("R5", "pulses with drops", n_rise - r0, 1);
    chk("R5", "drop strobes", n_drop - d0, 2);
    chk("R5", "strobe length", max_drun, 1);
  endtask

  task automatic t_glitch(input bit filt, input int exp_rise, input string req);
    int r0 = n_rise, d0 = n_drop;
    filt_en_n = ~filt;
    trig_a = 1'b1;
    @(negedge clk);
    trig_a = 1'b0;
    idle(SPACE + 8);
    chk(req, "pulses from glitch", n_rise - r0, exp_rise);
    chk(req, "strobes from glitch", n_drop - d0, 0);
  endtask

  task automatic t_disabled();
    int r0 = n_rise, d0 = n_drop;
    filt_en_n = 1'b1;
    en = 1'b0;
    fire();
    idle(10);
    en = 1'b1;
    idle(SPACE);
    chk("R8", "pulses while disabled", n_rise - r0, 0);
    chk("R8", "strobes while disabled", n_drop - d0, 0);
  endtask

  task automatic t_held();
    int r0 = n_rise, d0 = n_drop;
    filt_en_n = 1'b1;
    trig_a = 1'b1;
    idle(4 * SPACE);
    trig_a = 1'b0;
    idle(SPACE + 8);
    chk("R9", "pulses from held trigger", n_rise - r0, 1);
    chk("R9", "strobes from held trigger", n_drop - d0, 0);
  endtask

  initial begin
    t_reset();
    latency(1'b0, 4, "R2");
    latency(1'b1, 5, "R6");
    t_spacing(SPACE, 2, 0);
    t_spacing(SPACE - 1, 1, 1);
    t_multi_drop();
    t_glitch(1'b1, 0, "R6");
    t_glitch(1'b0, 1, "R7");
    t_disabled();
    t_held();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule